// File: doc/BRIEF.md
# Live-Time Counter with Held Upper-Byte Readout

This block keeps a running total of the live time of a pulse-height converter, in units of an externally supplied 10 ms tick. While the converter is free to accept a pulse, each tick adds one to a 24-bit total. While the front end is occupied, each tick subtracts one, to correct for the dead time. The first sign of occupation is an external busy level or the lower discriminator firing. From a peak detection or a pile-up reject until the front end is clear again, the total holds still. After a peak detection, that wait also lasts until the conversion has been read out.

The total is read in two parts without stopping the count. A read strobe presents the lower 16 bits and, in the same cycle, copies the upper 8 bits into a holding register. The upper part read later is taken from that register. Counting stops while the global inhibit is high or the local enable flag is low. A zero command or a module initialisation clears the total. Both take priority over a tick in the same cycle.

Top module: `live_time_clock`

## Requirements
- R1: After reset the total is zero, the held upper byte is zero, and the block is in the forward-counting condition.
- R2: In the forward condition each cycle with `tickEn` high adds one to the total; cycles without `tickEn` leave it unchanged.
- R3: A high `busyIn` or `discActive` switches the block to the backward condition from the next cycle, and each tick then subtracts one.
- R4: A `peakDet` or `pileUp` pulse moves the block to the hold condition from the next cycle, in which ticks do not change the total.
- R5: The hold condition returns to forward counting only when busy, discriminator and pile-up are all low and, if a peak was detected, `readoutDone` has been pulsed since that peak.
- R6: While `inhibitIn` is high or `enableFlag` is low, ticks do not change the total in any condition.
- R7: The total saturates: a forward tick at all ones and a backward tick at zero leave it unchanged.
- R8: A `rdLow` pulse copies the upper bits of the total (bits 23..16) into `highData` at the following edge; `highData` then keeps that value while the total moves on, until the next `rdLow` or initialisation.
- R9: When `rdLow` and a tick fall in the same cycle, `lowData` in that cycle and the captured `highData` both show the total before that tick.
- R10: `zeroCmd` clears the total at the next edge even when a tick arrives in the same cycle. `initClr` does the same, and also clears the held byte, returns to forward counting and drops any pending readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle 10 ms tick |
| busyIn | input | 1 | External busy level |
| discActive | input | 1 | Lower discriminator active level |
| peakDet | input | 1 | Peak detected pulse |
| pileUp | input | 1 | Pile-up reject pulse |
| readoutDone | input | 1 | Conversion readout finished pulse |
| inhibitIn | input | 1 | Global inhibit level |
| enableFlag | input | 1 | Local enable flag |
| zeroCmd | input | 1 | Clear total to zero |
| initClr | input | 1 | Module initialisation strobe |
| rdLow | input | 1 | Low-part read strobe, captures upper bits |
| lowData | output | 16 | Lower bits of the live total |
| highData | output | 8 | Upper bits held at the last low read |

## Verification
Two coincidences are at stake: a low read in the same cycle as a tick, and a clear in the same cycle as a tick. The bench makes the read and the tick coincide exactly where the tick carries into the upper byte. It then checks that the low value seen in that cycle and the captured upper byte form the pre-tick total, and that the next full read shows the carry. For the clear, a tick and a zero command, and later a tick and an initialisation, are raised in the same cycle. The bench then expects zero, and resumed forward counting from zero.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  typedef enum logic [1:0] {
    ST_FWD  = 2'd0,
    ST_BACK = 2'd1,
    ST_HOLD = 2'd2
  } ltcState_t;

  typedef struct packed {
    logic inc;
    logic dec;
    logic zero;
    logic clrHeld;
    logic capture;
  } ltcStrobe_t;

endpackage

// File: rtl/ltc_ctrl.sv
module ltc_ctrl
  import ltc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       busyIn,
  input  logic       discActive,
  input  logic       peakDet,
  input  logic       pileUp,
  input  logic       readoutDone,
  input  logic       inhibitIn,
  input  logic       enableFlag,
  input  logic       zeroCmd,
  input  logic       initClr,
  input  logic       rdLow,
  output ltcStrobe_t strobe
);

  ltcState_t state, stateNext;
  logic      pendRead, pendNext;
  logic      running;
  logic      frontBusy;

  assign running   = enableFlag && !inhibitIn;
  assign frontBusy = busyIn || discActive;

  always_comb begin
    pendNext = pendRead;
    if (peakDet)          pendNext = 1'b1;
    else if (readoutDone) pendNext = 1'b0;

    stateNext = state;
    unique case (state)
      ST_FWD: begin
        if (peakDet || pileUp) stateNext = ST_HOLD;
        else if (frontBusy)    stateNext = ST_BACK;
      end
      ST_BACK: begin
        if (peakDet || pileUp) stateNext = ST_HOLD;
        else if (!frontBusy)   stateNext = ST_FWD;
      end
      ST_HOLD: begin
        if (!peakDet && !pileUp && !frontBusy && !pendNext)
          stateNext = ST_FWD;
      end
      default: stateNext = ST_FWD;
    endcase

    if (initClr) begin
      stateNext = ST_FWD;
      pendNext  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_FWD;
      pendRead <= 1'b0;
    end else begin
      state    <= stateNext;
      pendRead <= pendNext;
    end
  end

  always_comb begin
    strobe.inc     = tickEn && running && (state == ST_FWD);
    strobe.dec     = tickEn && running && (state == ST_BACK);
    strobe.zero    = zeroCmd || initClr;
    strobe.clrHeld = initClr;
    strobe.capture = rdLow;
  end

endmodule

// File: rtl/ltc_datapath.sv
module ltc_datapath
  import ltc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ltcStrobe_t             strobe,
  output logic [CNT_W-1:0]       countNow,
  output logic [CNT_W-LOW_W-1:0] heldHigh
);

  localparam int HIGH_W = CNT_W - LOW_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.zero) begin
      count <= '0;
    end else if (strobe.inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end else if (strobe.dec && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldHigh <= '0;
    end else if (strobe.clrHeld) begin
      heldHigh <= '0;
    end else if (strobe.capture) begin
      heldHigh <= count[CNT_W-1 -: HIGH_W];
    end
  end

  assign countNow = count;

endmodule

// File: rtl/live_time_clock.sv
module live_time_clock
  import ltc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   busyIn,
  input  logic                   discActive,
  input  logic                   peakDet,
  input  logic                   pileUp,
  input  logic                   readoutDone,
  input  logic                   inhibitIn,
  input  logic                   enableFlag,
  input  logic                   zeroCmd,
  input  logic                   initClr,
  input  logic                   rdLow,
  output logic [LOW_W-1:0]       lowData,
  output logic [CNT_W-LOW_W-1:0] highData
);

  ltcStrobe_t       strobe;
  logic [CNT_W-1:0] countNow;

  ltc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .busyIn     (busyIn),
    .discActive (discActive),
    .peakDet    (peakDet),
    .pileUp     (pileUp),
    .readoutDone(readoutDone),
    .inhibitIn  (inhibitIn),
    .enableFlag (enableFlag),
    .zeroCmd    (zeroCmd),
    .initClr    (initClr),
    .rdLow      (rdLow),
    .strobe     (strobe)
  );

  ltc_datapath #(
    .CNT_W(CNT_W),
    .LOW_W(LOW_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .countNow(countNow),
    .heldHigh(highData)
  );

  assign lowData = countNow[LOW_W-1:0];

endmodule

// File: rtl/ltc_checker.sv
module ltc_checker #(
  parameter int CNT_W = 24,
  parameter int LOW_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   tickEn,
  input logic                   inhibitIn,
  input logic                   enableFlag,
  input logic                   zeroCmd,
  input logic                   initClr,
  input logic                   rdLow,
  input logic [CNT_W-1:0]       countNow,
  input logic [CNT_W-LOW_W-1:0] highData
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!enableFlag || inhibitIn) && !zeroCmd && !initClr) |=> $stable(countNow));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !zeroCmd && !initClr) |=> $stable(countNow));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zeroCmd || initClr) |=> (countNow == '0));

  // R7
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((countNow == CNT_MAX) && !zeroCmd && !initClr) |=> (countNow == CNT_MAX) || (countNow == CNT_MAX - 1'b1));

  // R7
  no_wrap_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((countNow == '0) && !zeroCmd && !initClr) |=> (countNow == '0) || (countNow == 1));

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdLow && !initClr) |=> (highData == $past(countNow[CNT_W-1:LOW_W])));

  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdLow && !initClr) |=> $stable(highData));

endmodule

bind live_time_clock ltc_checker #(
  .CNT_W(CNT_W),
  .LOW_W(LOW_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .inhibitIn (inhibitIn),
  .enableFlag(enableFlag),
  .zeroCmd   (zeroCmd),
  .initClr   (initClr),
  .rdLow     (rdLow),
  .countNow  (countNow),
  .highData  (highData)
);

// File: tb/live_time_clock_tb.sv
module live_time_clock_tb;

  localparam int CNT_W = 12;
  localparam int LOW_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, busyIn = 0, discActive = 0, peakDet = 0, pileUp = 0;
  logic readoutDone = 0, inhibitIn = 0, enableFlag = 1, zeroCmd = 0;
  logic initClr = 0, rdLow = 0;
  logic [LOW_W-1:0]       lowData;
  logic [CNT_W-LOW_W-1:0] highData;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int expv = 0;
  int got = 0;
  int loSeen = 0;

  always #4 clk = ~clk;

  live_time_clock #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busyIn(busyIn),
    .discActive(discActive), .peakDet(peakDet), .pileUp(pileUp),
    .readoutDone(readoutDone), .inhibitIn(inhibitIn), .enableFlag(enableFlag),
    .zeroCmd(zeroCmd), .initClr(initClr), .rdLow(rdLow),
    .lowData(lowData), .highData(highData)
  );

  task automatic chk(input string tag, input int act, input int want);
    total++;
    if (act != want) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, want);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readCount(output int v);
    int lo;
    rdLow = 1'b1;
    #1 lo = int'(lowData);
    @(negedge clk);
    rdLow = 1'b0;
    #1 v = (int'(highData) << LOW_W) | lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 held", int'(highData), 0);
    readCount(got); chk("R1 total", got, 0);
    tick(2); readCount(got); chk("R1 forward", got, 2);
    zeroCmd = 1; idle(1); zeroCmd = 0;

    // R2 / R7 forward sweep through saturation
    for (int k = 1; k <= MAXV + 2; k++) begin
      tick(1);
      readCount(got);
      chk("R2 sweep", got, (k > MAXV) ? MAXV : k);
    end
    chk("R7 top", got, MAXV);
    idle(5); readCount(got); chk("R2 idle", got, MAXV);

    // R3 backward with busy, then with discriminator
    busyIn = 1; idle(1);
    tick(10); readCount(got); chk("R3 busy", got, MAXV - 10);
    busyIn = 0; discActive = 1; idle(1);
    tick(5); readCount(got); chk("R3 disc", got, MAXV - 15);
    zeroCmd = 1; idle(1); zeroCmd = 0;
    tick(3); readCount(got); chk("R7 floor", got, 0);
    discActive = 0; idle(1);

    // R4 / R5 peak path
    tick(20); expv = 20;
    busyIn = 1; idle(1); tick(3); expv -= 3;
    peakDet = 1; idle(1); peakDet = 0;
    tick(4); readCount(got); chk("R4 peak hold", got, expv);
    busyIn = 0; idle(1);
    tick(2); readCount(got); chk("R5 waits readout", got, expv);
    readoutDone = 1; idle(1); readoutDone = 0;
    tick(3); expv += 3; readCount(got); chk("R5 resume", got, expv);

    // R4 / R5 pile-up path, no readout needed
    busyIn = 1; idle(1);
    pileUp = 1; idle(1); pileUp = 0;
    tick(3); readCount(got); chk("R4 pileup hold", got, expv);
    busyIn = 0; idle(1);
    tick(2); expv += 2; readCount(got); chk("R5 pileup resume", got, expv);

    // R5 readout done but busy still high
    discActive = 1; idle(1);
    peakDet = 1; idle(1); peakDet = 0;
    readoutDone = 1; idle(1); readoutDone = 0;
    tick(2); readCount(got); chk("R5 disc keeps hold", got, expv);
    discActive = 0; idle(1);
    tick(1); expv += 1; readCount(got); chk("R5 all clear", got, expv);

    // R6 inhibit and enable
    inhibitIn = 1; tick(3); readCount(got); chk("R6 inhibit fwd", got, expv);
    busyIn = 1; idle(1); tick(3); readCount(got); chk("R6 inhibit back", got, expv);
    busyIn = 0; idle(1);
    enableFlag = 0; tick(2); readCount(got); chk("R6 still inhibit", got, expv);
    inhibitIn = 0; tick(2); readCount(got); chk("R6 disabled", got, expv);
    enableFlag = 1; tick(1); expv += 1; readCount(got); chk("R6 reenabled", got, expv);

    // R8 held byte stays while total carries
    zeroCmd = 1; idle(1); zeroCmd = 0;
    tick(511);
    readCount(got); chk("R8 read", got, 511);
    tick(1);
    #1 chk("R8 held after carry", int'(highData), 1);
    chk("R8 low after carry", int'(lowData), 0);
    readCount(got); chk("R8 new read", got, 512);

    // R9 read and carrying tick in the same cycle
    tick(255);
    rdLow = 1; tickEn = 1;
    #1 loSeen = int'(lowData);
    @(negedge clk);
    rdLow = 0; tickEn = 0;
    #1 chk("R9 low pre-tick", loSeen, 255);
    chk("R9 held pre-tick", int'(highData), 2);
    readCount(got); chk("R9 after", got, 768);

    // R10 zero command against a tick
    zeroCmd = 1; tickEn = 1; idle(1); zeroCmd = 0; tickEn = 0;
    readCount(got); chk("R10 zero vs tick", got, 0);

    // R10 initialisation clears held, state and pending readout
    tick(261); readCount(got); chk("R10 setup", got, 261);
    peakDet = 1; idle(1); peakDet = 0;
    tick(2); readCount(got); chk("R10 frozen", got, 261);
    initClr = 1; tickEn = 1; idle(1); initClr = 0; tickEn = 0;
    #1 chk("R10 held cleared", int'(highData), 0);
    chk("R10 low cleared", int'(lowData), 0);
    tick(2); readCount(got); chk("R10 runs forward", got, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule